// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small RISC core. It takes two operands, an operation code and a flag index, and produces a result, a write strobe for the destination register, and the eight-bit status word. The status word is held inside the block, so the carry and zero inputs of chained operations come from the previous update.

The block covers addition and subtraction with and without carry in, compares, bitwise logic, complement, negate, increment, decrement, left and right shifts and rotates, nibble swap, and setting or clearing one status flag. Each operation changes only its own group of flags. Compares change the flags but write no result. An immediate operand is presented on the second operand port, so immediate forms use the same codes as their register forms.

A one-cycle `go_i` strobe starts an operation. The result, the write strobe and the new status word appear together after the next rising clock edge.

Top module: `alu8_flags`

## Requirements
- R1: A synchronous active-high reset clears the status word, the result and the write strobe to zero.
- R2: Operation codes are ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, NEG=6, AND=7, OR=8, EOR=9, COM=10, INC=11, DEC=12, LSL=13, ROL=14, LSR=15, ROR=16, ASR=17, SWAP=18, FSET=19, FCLR=20. Codes 21 to 31 do nothing. When `go_i` is high at a rising edge, the outputs take their new values at that edge. In any other cycle the write strobe is low, and the result and the status word hold their values. The result changes only when the write strobe is set.
- R3: Status bits, from bit 0 upward, are C, Z, N, V, S, H, T and I. ADD and ADC (ADC adds C) set C to the carry out of bit 7, H to the carry out of bit 3, V to signed overflow, N to bit 7, Z when the result is zero, and S to N xor V.
- R4: SUB and SBC (SBC also subtracts C) and NEG (0 minus the first operand) set C to the borrow out of bit 7, H to the borrow into bit 4, V to signed overflow, and N, Z and S as in R3.
- R5: For SBC and CPC, Z is set only if the result is zero and Z was already set.
- R6: CP and CPC update the flags exactly as SUB and SBC would, but leave the write strobe low and the result unchanged.
- R7: AND, OR and EOR clear V, set Z, N and S from the result, and leave C and H unchanged.
- R8: COM writes the bitwise inverse of the first operand, sets C and clears V. INC and DEC leave C and H unchanged. V is set when INC gives 0x80 or when DEC gives 0x7F.
- R9: LSL shifts 0 into bit 0 and ROL shifts the old C into bit 0. Both put the old bit 7 into C and the old bit 3 into H, and set V to N xor C.
- R10: LSR shifts 0 into bit 7, ROR shifts the old C into bit 7, and ASR keeps bit 7. All three put the old bit 0 into C, set V to N xor C, and leave H unchanged.
- R11: SWAP writes the first operand with its two nibbles exchanged and leaves every flag unchanged.
- R12: FSET and FCLR set or clear the status bit selected by `bsel_i`, change no other bit, and do not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Starts the operation presented this cycle |
| op_i | input | 5 | Operation code (see R2) |
| opa_i | input | 8 | First operand (destination register value) |
| opb_i | input | 8 | Second operand (register value or immediate) |
| bsel_i | input | 3 | Status bit index for FSET and FCLR |
| res_o | output | 8 | Registered result |
| res_we_o | output | 1 | Result write strobe, high for one cycle |
| sreg_o | output | 8 | Registered status word |

## Verification
The assertions assume that `op_i`, the operands and `bsel_i` are stable around the edge where `go_i` is sampled. They also assume that nothing other than the block's own operations changes the status word. The bench drives every input at the falling edge, pulses `go_i` for exactly one cycle and leaves an idle cycle between operations. It builds every starting flag state only through FSET and FCLR, and so stays within those assumptions.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int SRW = 8;
  localparam int SIW = $clog2(SRW);

  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CP  = 5'd4,  OP_CPC = 5'd5,  OP_NEG = 5'd6,  OP_AND = 5'd7,
    OP_OR  = 5'd8,  OP_EOR = 5'd9,  OP_COM = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_LSL = 5'd13, OP_ROL = 5'd14, OP_LSR = 5'd15,
    OP_ROR = 5'd16, OP_ASR = 5'd17, OP_SWP = 5'd18, OP_FST = 5'd19,
    OP_FCL = 5'd20
  } alu_op_e;

  // Which status bits an operation owns (C,Z,N,V,S,H = bits 0..5)
  function automatic logic [SRW-1:0] flag_mask(input alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG,
      OP_LSL, OP_ROL:                        flag_mask = 8'h3F;
      OP_COM, OP_LSR, OP_ROR, OP_ASR:        flag_mask = 8'h1F;
      OP_AND, OP_OR, OP_EOR, OP_INC, OP_DEC: flag_mask = 8'h1E;
      default:                               flag_mask = 8'h00;
    endcase
  endfunction

  function automatic logic op_writes(input alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_AND, OP_OR, OP_EOR,
      OP_COM, OP_INC, OP_DEC, OP_LSL, OP_ROL, OP_LSR, OP_ROR, OP_ASR,
      OP_SWP:  op_writes = 1'b1;
      default: op_writes = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] r,
  output logic          c,
  output logic          h,
  output logic          v
);
  localparam int HB = DW / 2;
  localparam int M  = DW - 1;

  logic [DW-1:0] bop;
  logic          ci;
  logic [DW:0]   sum;
  logic [HB:0]   lo;

  // Subtraction as a + ~b + 1 - borrow; carry outputs invert into borrows
  always_comb begin
    bop = sub ? ~b : b;
    ci  = sub ? ~cin : cin;
    sum = {1'b0, a} + {1'b0, bop} + {{DW{1'b0}}, ci};
    lo  = {1'b0, a[HB-1:0]} + {1'b0, bop[HB-1:0]} + {{HB{1'b0}}, ci};
    r   = sum[DW-1:0];
    c   = sub ? ~sum[DW] : sum[DW];
    h   = sub ? ~lo[HB] : lo[HB];
    v   = (a[M] == bop[M]) && (r[M] != a[M]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] r,
  output logic          c,
  output logic          v
);
  localparam int HB = DW / 2;
  localparam int M  = DW - 1;
  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

  always_comb begin
    r = a;
    c = cin;
    v = 1'b0;
    case (op)
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_EOR: r = a ^ b;
      OP_COM: begin r = ~a; c = 1'b1; end
      OP_INC: begin r = a + ONE; v = (r == SMIN); end
      OP_DEC: begin r = a - ONE; v = (r == SMAX); end
      OP_LSL: begin r = {a[M-1:0], 1'b0}; c = a[M]; end
      OP_ROL: begin r = {a[M-1:0], cin};  c = a[M]; end
      OP_LSR: begin r = {1'b0, a[M:1]};   c = a[0]; end
      OP_ROR: begin r = {cin, a[M:1]};    c = a[0]; end
      OP_ASR: begin r = {a[M], a[M:1]};   c = a[0]; end
      OP_SWP: r = {a[HB-1:0], a[DW-1:HB]};
      default: r = a;
    endcase
    if (op inside {OP_LSL, OP_ROL, OP_LSR, OP_ROR, OP_ASR})
      v = r[M] ^ c;
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go_i,
  input  logic [4:0]     op_i,
  input  logic [DW-1:0]  opa_i,
  input  logic [DW-1:0]  opb_i,
  input  logic [SIW-1:0] bsel_i,
  output logic [DW-1:0]  res_o,
  output logic           res_we_o,
  output logic [SRW-1:0] sreg_o
);
  localparam int HB = DW / 2;
  localparam int M  = DW - 1;

  alu_op_e       op;
  logic [DW-1:0] ax, ay, ar, br, rr;
  logic          aci, asub, ac, ah, av, bc, bv;
  logic          is_arith, chain_z;
  logic [SRW-1:0] nf, mask, nxt;

  assign op = alu_op_e'(op_i);

  always_comb begin
    ax   = opa_i;
    ay   = opb_i;
    aci  = 1'b0;
    asub = 1'b1;
    case (op)
      OP_ADD:         asub = 1'b0;
      OP_ADC:         begin asub = 1'b0; aci = sreg_o[FC]; end
      OP_SBC, OP_CPC: aci = sreg_o[FC];
      OP_NEG:         begin ax = '0; ay = opa_i; end
      default:        asub = 1'b1;
    endcase
  end

  alu8_addsub #(.DW(DW)) u_as (
    .a(ax), .b(ay), .cin(aci), .sub(asub), .r(ar), .c(ac), .h(ah), .v(av)
  );

  alu8_bitops #(.DW(DW)) u_bo (
    .op(op), .a(opa_i), .b(opb_i), .cin(sreg_o[FC]), .r(br), .c(bc), .v(bv)
  );

  assign is_arith = op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_CPC, OP_NEG};
  assign chain_z  = op inside {OP_SBC, OP_CPC};
  assign rr       = is_arith ? ar : br;
  assign mask     = flag_mask(op);

  always_comb begin
    nf     = '0;
    nf[FC] = is_arith ? ac : bc;
    nf[FH] = is_arith ? ah : opa_i[HB-1];
    nf[FN] = rr[M];
    nf[FV] = is_arith ? av : bv;
    nf[FZ] = (rr == '0) && (!chain_z || sreg_o[FZ]);
    nf[FS] = nf[FN] ^ nf[FV];
    nxt    = (sreg_o & ~mask) | (nf & mask);
    if (op == OP_FST) nxt[bsel_i] = 1'b1;
    if (op == OP_FCL) nxt[bsel_i] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_o   <= '0;
      res_o    <= '0;
      res_we_o <= 1'b0;
    end else if (go_i) begin
      sreg_o   <= nxt;
      res_we_o <= op_writes(op);
      if (op_writes(op)) res_o <= rr;
    end else begin
      res_we_o <= 1'b0;
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (sreg_o == '0 && res_o == '0 && !res_we_o));

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !go_i |=> (!res_we_o && $stable(sreg_o) && $stable(res_o)));

  a_r3_sign_rule: assert property (@(posedge clk) disable iff (rst)
    (go_i && op_i <= 5'd6) |=> (sreg_o[FS] == (sreg_o[FN] ^ sreg_o[FV])));

  a_r6_compare_nowrite: assert property (@(posedge clk) disable iff (rst)
    (go_i && (op_i == 5'd4 || op_i == 5'd5)) |=> (!res_we_o && $stable(res_o)));

  a_r7_logic_keeps_ch: assert property (@(posedge clk) disable iff (rst)
    (go_i && op_i >= 5'd7 && op_i <= 5'd9) |=>
      (!sreg_o[FV] && sreg_o[FC] == $past(sreg_o[FC]) && sreg_o[FH] == $past(sreg_o[FH])));

  a_r8_com_carry: assert property (@(posedge clk) disable iff (rst)
    (go_i && op_i == 5'd10) |=> (sreg_o[FC] && !sreg_o[FV]));

  a_r11_swap_flags: assert property (@(posedge clk) disable iff (rst)
    (go_i && op_i == 5'd18) |=> (res_we_o && sreg_o == $past(sreg_o)));

  a_r12_single_flag: assert property (@(posedge clk) disable iff (rst)
    (go_i && (op_i == 5'd19 || op_i == 5'd20)) |=>
      (!res_we_o && $countones(sreg_o ^ $past(sreg_o)) <= 1));
endmodule

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  localparam bit [4:0] ADD=0, ADC=1, SUB=2, SBC=3, CP=4, CPC=5, NEG=6, AND_=7,
    OR_=8, EOR=9, COM=10, INC=11, DEC=12, LSL=13, ROL=14, LSR=15, ROR=16,
    ASR=17, SWP=18, FST=19, FCL=20;

  logic       clk = 0;
  logic       rst = 1;
  logic       go_i = 0;
  logic [4:0] op_i = 0;
  logic [7:0] opa_i = 0, opb_i = 0;
  logic [2:0] bsel_i = 0;
  logic [7:0] res_o, sreg_o;
  logic       res_we_o;

  int total = 0, bad = 0;
  logic [7:0] sr_m = 0, res_m = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  alu8_flags uut (.clk(clk), .rst(rst), .go_i(go_i), .op_i(op_i), .opa_i(opa_i),
    .opb_i(opb_i), .bsel_i(bsel_i), .res_o(res_o), .res_we_o(res_we_o), .sreg_o(sreg_o));

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int sx(int x);
    return (x > 127) ? x - 256 : x;
  endfunction

  // Reference model written from the requirements
  task automatic model(input bit [4:0] op, input int a, input int b, input int idx,
                       output int r, output bit we, output logic [7:0] s);
    int c, full, sv;
    bit fc, fz, fn, fv, fh, uc, uz, un, uv, us, uh, isub, chain;
    c = sr_m[0];
    s = sr_m; r = res_m; we = 0;
    {fc, fz, fn, fv, fh, uc, uz, un, uv, us, uh} = '0;
    isub = 0; chain = 0;
    case (op)
      ADD, ADC: begin
        int ci = (op == ADC) ? c : 0;
        full = a + b + ci; r = full & 255; fc = full > 255;
        fh = ((a & 15) + (b & 15) + ci) > 15;
        sv = sx(a) + sx(b) + ci; fv = (sv > 127) || (sv < -128);
        {uc, uz, un, uv, us, uh} = '1; we = 1;
      end
      SUB, SBC, CP, CPC, NEG: begin
        int ci = (op == SBC || op == CPC) ? c : 0;
        int x = (op == NEG) ? 0 : a;
        int y = (op == NEG) ? a : b;
        full = x - y - ci; r = full & 255; fc = full < 0;
        fh = (x & 15) < ((y & 15) + ci);
        sv = sx(x) - sx(y) - ci; fv = (sv > 127) || (sv < -128);
        {uc, uz, un, uv, us, uh} = '1;
        we = !(op == CP || op == CPC);
        chain = (op == SBC || op == CPC);
      end
      AND_, OR_, EOR: begin
        r = (op == AND_) ? (a & b) : (op == OR_) ? (a | b) : (a ^ b);
        fv = 0; {uz, un, uv, us} = '1; we = 1;
      end
      COM: begin r = 255 - a; fc = 1; fv = 0; {uc, uz, un, uv, us} = '1; we = 1; end
      INC: begin r = (a + 1) & 255; fv = (a == 127); {uz, un, uv, us} = '1; we = 1; end
      DEC: begin r = (a + 255) & 255; fv = (a == 128); {uz, un, uv, us} = '1; we = 1; end
      LSL, ROL: begin
        r = ((a << 1) & 255) | ((op == ROL) ? c : 0);
        fc = a[7]; fh = a[3]; fv = r[7] ^ fc;
        {uc, uz, un, uv, us, uh} = '1; we = 1;
      end
      LSR, ROR, ASR: begin
        r = (a >> 1) | ((op == ROR) ? (c << 7) : (op == ASR) ? (a & 128) : 0);
        fc = a[0]; fv = r[7] ^ fc;
        {uc, uz, un, uv, us} = '1; we = 1;
      end
      SWP: begin r = ((a & 15) << 4) | (a >> 4); we = 1; end
      FST: s[idx] = 1'b1;
      FCL: s[idx] = 1'b0;
      default: ;
    endcase
    if (we || uz) begin
      fn = r[7];
      fz = (r == 0) && (!chain || sr_m[1]);
    end
    if (uc) s[0] = fc;
    if (uz) s[1] = fz;
    if (un) s[2] = fn;
    if (uv) s[3] = fv;
    if (us) s[4] = fn ^ fv;
    if (uh) s[5] = fh;
    if (!we) r = res_m;
  endtask

  task automatic do_op(string tag, bit [4:0] op, int a, int b, int idx = 0);
    int r; bit we; logic [7:0] s;
    model(op, a, b, idx, r, we, s);
    @(negedge clk);
    op_i = op; opa_i = 8'(a); opb_i = 8'(b); bsel_i = 3'(idx); go_i = 1;
    @(negedge clk);
    go_i = 0;
    check(tag, "result", int'(res_o), r);
    check(tag, "write", int'(res_we_o), int'(we));
    check(tag, "status", int'(sreg_o), int'(s));
    sr_m = s; res_m = 8'(r);
  endtask

  task automatic set_flags(logic [7:0] v);
    for (int i = 0; i < 8; i++) do_op("R12", v[i] ? FST : FCL, 0, 0, i);
  endtask

  task automatic t_reset;
    check("R1", "status", int'(sreg_o), 0);
    check("R1", "result", int'(res_o), 0);
    check("R1", "write", int'(res_we_o), 0);
  endtask

  task automatic t_add;
    do_op("R3", ADD, 8'h0F, 8'h01);
    do_op("R3", ADD, 8'h7F, 8'h01);
    do_op("R3", ADD, 8'hFF, 8'h01);
    check("R3", "carry+zero literal", int'(sreg_o & 8'h03), 3);
    do_op("R3", ADC, 8'h10, 8'h20);
    do_op("R3", ADD, 8'h80, 8'h80);
    set_flags(8'h01);
    do_op("R3", ADC, 8'h0E, 8'h01);
  endtask

  task automatic t_sub;
    do_op("R4", SUB, 8'h10, 8'h01);
    do_op("R4", SUB, 8'h80, 8'h01);
    do_op("R4", SUB, 8'h00, 8'h01);
    do_op("R4", SBC, 8'h05, 8'h02);
    do_op("R4", NEG, 8'h80, 0);
    do_op("R4", NEG, 8'h00, 0);
    do_op("R4", NEG, 8'h01, 0);
  endtask

  task automatic t_chain;
    do_op("R5", SUB, 8'h00, 8'h00);
    do_op("R5", SBC, 8'h00, 8'h00);
    check("R5", "zero kept", int'(sreg_o[1]), 1);
    do_op("R5", SBC, 8'h03, 8'h01);
    do_op("R5", SBC, 8'h00, 8'h00);
    check("R5", "zero not re-set", int'(sreg_o[1]), 0);
    do_op("R5", CP, 8'h00, 8'h00);
    do_op("R5", CPC, 8'h01, 8'h01);
  endtask

  task automatic t_cmp;
    do_op("R6", ADD, 8'h11, 8'h22);
    do_op("R6", CP, 8'h05, 8'h05);
    do_op("R6", CP, 8'h03, 8'h09);
    do_op("R6", CPC, 8'h09, 8'h03);
    check("R6", "result untouched", int'(res_o), 8'h33);
  endtask

  task automatic t_logic;
    set_flags(8'h21);
    do_op("R7", AND_, 8'hF0, 8'h0F);
    do_op("R7", OR_, 8'h80, 8'h01);
    set_flags(8'h08);
    do_op("R7", EOR, 8'h55, 8'h55);
  endtask

  task automatic t_unary;
    set_flags(8'h20);
    do_op("R8", COM, 8'h00, 0);
    do_op("R8", COM, 8'hFF, 0);
    do_op("R8", INC, 8'h7F, 0);
    do_op("R8", INC, 8'hFF, 0);
    do_op("R8", DEC, 8'h80, 0);
    do_op("R8", DEC, 8'h01, 0);
  endtask

  task automatic t_left;
    do_op("R9", LSL, 8'h88, 0);
    do_op("R9", ROL, 8'h40, 0);
    do_op("R9", LSL, 8'h40, 0);
    do_op("R9", ROL, 8'h00, 0);
  endtask

  task automatic t_right;
    set_flags(8'h21);
    do_op("R10", ROR, 8'h02, 0);
    do_op("R10", LSR, 8'h01, 0);
    do_op("R10", ASR, 8'h81, 0);
    set_flags(8'h01);
    do_op("R10", ROR, 8'h01, 0);
  endtask

  task automatic t_swap;
    set_flags(8'h5A);
    do_op("R11", SWP, 8'h3C, 0);
    do_op("R11", SWP, 8'h00, 0);
  endtask

  task automatic t_flags;
    set_flags(8'h00);
    do_op("R12", FST, 0, 0, 7);
    do_op("R12", FST, 0, 0, 6);
    do_op("R12", FCL, 0, 0, 7);
    check("R12", "literal", int'(sreg_o), 8'h40);
  endtask

  task automatic t_idle;
    logic [7:0] s0, r0;
    s0 = sreg_o; r0 = res_o;
    @(negedge clk);
    op_i = ADD; opa_i = 8'hFF; opb_i = 8'hFF; go_i = 0;
    repeat (3) @(negedge clk);
    check("R2", "idle status", int'(sreg_o), int'(s0));
    check("R2", "idle result", int'(res_o), int'(r0));
    check("R2", "idle write", int'(res_we_o), 0);
    do_op("R2", 5'd25, 8'h12, 8'h34);
    do_op("R2", 5'd31, 8'hFF, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_add();
    t_sub();
    t_chain();
    t_cmp();
    t_logic();
    t_unary();
    t_left();
    t_right();
    t_swap();
    t_flags();
    t_idle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule